// File: doc/BRIEF.md
# Flash Sector Write-Protection Guard

This block sits beside the command engine of a sector-organised flash array. It rules on every program or erase request before any high-voltage step starts. Each sector holds 64K words. The sector count is a parameter: 128, 256 or 512, and any power of two of at least two works.

Four protection sources are combined into one verdict:
- **Write-protect pin.** Guards a single boot sector. A strap chooses whether that is the lowest or the highest sector.
- **Persistent protection.** One bit per sector, given as an input vector.
- **Password gate.** A 64-bit password gate that, in password mode, keeps persistently protected sectors closed until the matching password is presented.
- **Secured-region lock.** A one-way lock on the separate 128-word secured region, which holds the serial number area.

A low-supply flag overrides everything. The verdict for a request comes back combinationally in the cycle the request is presented, together with a reason code. A chip-erase request is never refused for protection. Instead it returns a mask of the sectors the erase must skip.

Top module: `sector_guard`

## Requirements
- R1: While `reqValid` is high, exactly one of `grant` and `reject` is high in that same cycle. While `reqValid` is low, both are low, `rejectReason` is 0 and `skipMask` is 0.
- R2: While `lowSupply` is high, every request is rejected with reason 1 (low supply), whatever its kind. This reason outranks all others.
- R3: With `wpPinN` low, a program (op 0) or sector erase (op 1) to the pin sector of the main array is rejected with reason 3. The pin sector is sector 0 when `bootTop` is 0 and sector SECTORS-1 when it is 1. Other sectors are not affected by the pin.
- R4: With `pwdMode` low, a program or sector erase to a main-array sector whose `ppbBits` bit is 1 is rejected with reason 5 (persistent).
- R5: With `pwdMode` high and the gate locked, such a request is rejected with reason 4 (password). A `pwdTry` whose `pwdData` equals the stored password sets `pwdUnlocked` at the next clock edge. From then on, persistent bits no longer block requests.
- R6: A `pwdTry` whose data does not match leaves `pwdUnlocked` unchanged. It raises `pwdErr` for exactly the one cycle after the try.
- R7: The stored password resets to all ones. `pwdLoad` replaces it with `pwdData` only while `pwdMode` is low or the gate is unlocked; otherwise the load is ignored. `pwdLock` clears `pwdUnlocked` at the next edge.
- R8: A program or sector erase with `reqSecured` high targets the secured region, where the pin and the persistent bits do not apply. After a `secLockSet` pulse, `secLocked` is high from the next edge until reset. Every such request is then rejected with reason 2 (secured lock).
- R9: A chip erase (op 2) is granted unless `lowSupply` is high. `skipMask` then holds the protected sectors: the pin sector when `wpPinN` is low, plus the `ppbBits` sectors unless password mode is unlocked.
- R10: When several reasons apply, the reported one follows this order: low supply, secured lock, pin, password, persistent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqOp | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 acts as program |
| reqSector | input | log2(SECTORS) | Target sector of the main array |
| reqSecured | input | 1 | Request targets the secured region |
| wpPinN | input | 1 | Write-protect pin, low protects the boot sector |
| bootTop | input | 1 | Strap: 1 selects the highest sector as pin sector |
| lowSupply | input | 1 | Supply below write threshold |
| ppbBits | input | SECTORS | Persistent protection, one bit per sector |
| pwdMode | input | 1 | Password protection mode active |
| pwdData | input | 64 | Password for load or try |
| pwdLoad | input | 1 | Store `pwdData` as password |
| pwdTry | input | 1 | Compare `pwdData` against the stored password |
| pwdLock | input | 1 | Re-lock the password gate |
| secLockSet | input | 1 | Lock the secured region permanently |
| grant | output | 1 | Request may proceed |
| reject | output | 1 | Request refused |
| rejectReason | output | 3 | 0 none, 1 low supply, 2 secured lock, 3 pin, 4 password, 5 persistent |
| skipMask | output | SECTORS | Sectors a granted chip erase must skip |
| pwdErr | output | 1 | One-cycle pulse after a failed password try |
| pwdUnlocked | output | 1 | Password gate open |
| secLocked | output | 1 | Secured region locked |

## Verification
Some properties hold on every cycle, and the embedded assertions watch those:
- A present request gets exactly one verdict, and an idle cycle is quiet.
- Low supply never lets a grant through.
- The pin sector is always refused while the pin is low, and it always appears in a chip-erase skip mask.
- The secured lock never falls, a matching try opens the gate, and a mismatch leaves the gate as it was.

Other behaviour depends on history, and only the bench's sequences can show it:
- the reason priority when sources overlap;
- a password load being ignored while locked, shown by the old password still opening the gate;
- a load while unlocked taking effect after a relock;
- the secured region ignoring the pin.

// File: rtl/sector_guard_pkg.sv
package sector_guard_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2,
    OP_RSVD   = 2'd3
  } guardOp_e;

  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_LOWSUP   = 3'd1,
    RSN_SECLOCK  = 3'd2,
    RSN_PIN      = 3'd3,
    RSN_PASSWORD = 3'd4,
    RSN_PERSIST  = 3'd5
  } guardReason_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPwd;    // write the password register this cycle
    logic ppbBypass;  // persistent bits opened by the password gate
  } guardStrobe_t;

endpackage

// File: rtl/sector_guard_ctrl.sv
module sector_guard_ctrl
  import sector_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pwdMode,
  input  logic         pwdLoad,
  input  logic         pwdTry,
  input  logic         pwdLock,
  input  logic         pwdEqual,
  input  logic         secLockSet,
  output guardStrobe_t strobe,
  output logic         unlocked,
  output logic         pwdErr,
  output logic         secLocked
);

  logic gateClosed;

  assign gateClosed       = pwdMode && !unlocked;
  assign strobe.loadPwd   = pwdLoad && !gateClosed;
  assign strobe.ppbBypass = pwdMode && unlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked <= 1'b0;
    end else if (pwdLock) begin
      unlocked <= 1'b0;
    end else if (pwdTry && pwdEqual) begin
      unlocked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwdErr <= 1'b0;
    end else begin
      pwdErr <= pwdTry && !pwdEqual;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secLocked <= 1'b0;
    end else if (secLockSet) begin
      secLocked <= 1'b1;
    end
  end

  AST_SEC_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    secLocked |=> secLocked); // R8

  AST_MATCH_UNLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (pwdTry && pwdEqual && !pwdLock) |=> unlocked); // R5

  AST_MISS_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (pwdErr && !$past(pwdLock)) |-> $stable(unlocked)); // R6

endmodule

// File: rtl/sector_guard_dp.sv
module sector_guard_dp
  import sector_guard_pkg::*;
#(
  parameter int SECTORS = 128,
  parameter int PWD_W   = 64,
  localparam int SECT_W = $clog2(SECTORS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  guardStrobe_t        strobe,
  input  logic [PWD_W-1:0]    pwdData,
  input  logic                pwdMode,
  input  logic                secLocked,
  input  logic                reqValid,
  input  guardOp_e            reqOp,
  input  logic [SECT_W-1:0]   reqSector,
  input  logic                reqSecured,
  input  logic                wpPinN,
  input  logic                bootTop,
  input  logic                lowSupply,
  input  logic [SECTORS-1:0]  ppbBits,
  output logic                pwdEqual,
  output logic                grant,
  output logic                reject,
  output guardReason_e        rejectReason,
  output logic [SECTORS-1:0]  skipMask
);

  localparam logic [SECT_W-1:0] TOP_IDX = SECT_W'(SECTORS - 1);

  logic [PWD_W-1:0]   storedPwd;
  logic [SECT_W-1:0]  pinIdx;
  logic [SECTORS-1:0] pinMask;
  logic [SECTORS-1:0] ppbLive;
  logic [SECTORS-1:0] protMask;
  guardReason_e       verdict;
  logic               chipErase;

  // password register, erased state all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedPwd <= '1;
    end else if (strobe.loadPwd) begin
      storedPwd <= pwdData;
    end
  end

  assign pwdEqual = (pwdData == storedPwd);

  assign pinIdx = bootTop ? TOP_IDX : '0;

  for (genvar i = 0; i < SECTORS; i++) begin : g_pin
    assign pinMask[i] = !wpPinN && (pinIdx == SECT_W'(i));
  end

  assign ppbLive   = strobe.ppbBypass ? '0 : ppbBits;
  assign protMask  = pinMask | ppbLive;
  assign chipErase = (reqOp == OP_CERASE);

  always_comb begin
    verdict = RSN_NONE;
    if (lowSupply) begin
      verdict = RSN_LOWSUP;
    end else if (chipErase) begin
      verdict = RSN_NONE;
    end else if (reqSecured) begin
      verdict = secLocked ? RSN_SECLOCK : RSN_NONE;
    end else if (pinMask[reqSector]) begin
      verdict = RSN_PIN;
    end else if (ppbLive[reqSector]) begin
      verdict = pwdMode ? RSN_PASSWORD : RSN_PERSIST;
    end
  end

  assign rejectReason = reqValid ? verdict : RSN_NONE;
  assign reject       = reqValid && (verdict != RSN_NONE);
  assign grant        = reqValid && (verdict == RSN_NONE);
  assign skipMask     = (reqValid && chipErase && !lowSupply) ? protMask : '0;

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ($countones({grant, reject}) == 1)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!grant && !reject && skipMask == '0)); // R1

  AST_LOW_SUPPLY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lowSupply) |-> !grant); // R2

  AST_PIN_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !wpPinN && !reqSecured && reqOp != OP_CERASE &&
     reqSector == (bootTop ? TOP_IDX : '0)) |-> reject); // R3

  AST_CHIP_SKIPS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (grant && reqOp == OP_CERASE && !wpPinN) |->
      skipMask[bootTop ? TOP_IDX : '0]); // R9

endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sector_guard_pkg::*;
#(
  parameter int SECTORS = 128,
  localparam int SECT_W = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqOp,
  input  logic [SECT_W-1:0]  reqSector,
  input  logic               reqSecured,
  input  logic               wpPinN,
  input  logic               bootTop,
  input  logic               lowSupply,
  input  logic [SECTORS-1:0] ppbBits,
  input  logic               pwdMode,
  input  logic [63:0]        pwdData,
  input  logic               pwdLoad,
  input  logic               pwdTry,
  input  logic               pwdLock,
  input  logic               secLockSet,
  output logic               grant,
  output logic               reject,
  output logic [2:0]         rejectReason,
  output logic [SECTORS-1:0] skipMask,
  output logic               pwdErr,
  output logic               pwdUnlocked,
  output logic               secLocked
);

  guardStrobe_t strobe;
  logic         pwdEqual;
  guardReason_e reasonCode;

  sector_guard_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwdMode   (pwdMode),
    .pwdLoad   (pwdLoad),
    .pwdTry    (pwdTry),
    .pwdLock   (pwdLock),
    .pwdEqual  (pwdEqual),
    .secLockSet(secLockSet),
    .strobe    (strobe),
    .unlocked  (pwdUnlocked),
    .pwdErr    (pwdErr),
    .secLocked (secLocked)
  );

  sector_guard_dp #(.SECTORS(SECTORS), .PWD_W(64)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .pwdData     (pwdData),
    .pwdMode     (pwdMode),
    .secLocked   (secLocked),
    .reqValid    (reqValid),
    .reqOp       (guardOp_e'(reqOp)),
    .reqSector   (reqSector),
    .reqSecured  (reqSecured),
    .wpPinN      (wpPinN),
    .bootTop     (bootTop),
    .lowSupply   (lowSupply),
    .ppbBits     (ppbBits),
    .pwdEqual    (pwdEqual),
    .grant       (grant),
    .reject      (reject),
    .rejectReason(reasonCode),
    .skipMask    (skipMask)
  );

  assign rejectReason = reasonCode;

endmodule

// File: tb/sector_guard_test.sv
module sector_guard_test;

  localparam int PERIOD = 10;
  localparam int Q      = PERIOD / 4;
  localparam int NSEC   = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid = 0;
  logic [1:0]  reqOp = 0;
  logic [3:0]  reqSector = 0;
  logic        reqSecured = 0;
  logic        wpPinN = 1;
  logic        bootTop = 0;
  logic        lowSupply = 0;
  logic [15:0] ppbBits = 0;
  logic        pwdMode = 0;
  logic [63:0] pwdData = 0;
  logic        pwdLoad = 0;
  logic        pwdTry = 0;
  logic        pwdLock = 0;
  logic        secLockSet = 0;
  logic        grant, reject, pwdErr, pwdUnlocked, secLocked;
  logic [2:0]  rejectReason;
  logic [15:0] skipMask;

  int total = 0;
  int bad   = 0;

  // bench-side state from the requirements
  logic        mUnlocked = 0;
  logic        mSecLocked = 0;

  typedef struct {
    logic        g;
    logic [2:0]  r;
    logic [15:0] s;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #(PERIOD/2) clk = ~clk;

  sector_guard #(.SECTORS(NSEC)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqSector(reqSector), .reqSecured(reqSecured), .wpPinN(wpPinN),
    .bootTop(bootTop), .lowSupply(lowSupply), .ppbBits(ppbBits),
    .pwdMode(pwdMode), .pwdData(pwdData), .pwdLoad(pwdLoad),
    .pwdTry(pwdTry), .pwdLock(pwdLock), .secLockSet(secLockSet),
    .grant(grant), .reject(reject), .rejectReason(rejectReason),
    .skipMask(skipMask), .pwdErr(pwdErr), .pwdUnlocked(pwdUnlocked),
    .secLocked(secLocked)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected verdict computed from R2..R10
  function automatic expItem_t model(input string tag);
    expItem_t e;
    logic [15:0] pinM;
    logic [15:0] ppbM;
    int pinSec;
    pinSec = bootTop ? NSEC - 1 : 0;
    pinM = '0;
    if (!wpPinN) pinM[pinSec] = 1'b1;
    ppbM = (pwdMode && mUnlocked) ? 16'h0 : ppbBits;
    e.tag = tag;
    e.s = '0;
    if (lowSupply) e.r = 3'd1;
    else if (reqOp == 2'd2) begin
      e.r = 3'd0;
      e.s = pinM | ppbM;
    end
    else if (reqSecured) e.r = mSecLocked ? 3'd2 : 3'd0;
    else if (pinM[reqSector]) e.r = 3'd3;
    else if (ppbM[reqSector]) e.r = pwdMode ? 3'd4 : 3'd5;
    else e.r = 3'd0;
    e.g = (e.r == 3'd0);
    return e;
  endfunction

  // driver: called at a falling edge, holds the request for one cycle
  task automatic drive(input string tag, input logic [1:0] op,
                       input int sec, input logic secured);
    reqOp      = op;
    reqSector  = 4'(sec);
    reqSecured = secured;
    reqValid   = 1'b1;
    expQ.push_back(model(tag));
    @(negedge clk);
    reqValid   = 1'b0;
    reqSecured = 1'b0;
  endtask

  // monitor: samples a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #Q;
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check({e.tag, " grant"},  64'(grant),        64'(e.g));
        check({e.tag, " reject"}, 64'(reject),       64'(!e.g));
        check({e.tag, " reason"}, 64'(rejectReason), 64'(e.r));
        check({e.tag, " skip"},   64'(skipMask),     64'(e.s));
      end
    end
  end

  task automatic tryPwd(input string tag, input logic [63:0] val, input logic match);
    pwdData = val;
    pwdTry  = 1'b1;
    @(negedge clk);
    pwdTry  = 1'b0;
    if (match) mUnlocked = 1'b1;
    #Q;
    check({tag, " err"},      64'(pwdErr),      64'(!match));
    check({tag, " unlocked"}, 64'(pwdUnlocked), 64'(mUnlocked));
    @(negedge clk);
    #Q;
    check({tag, " R6 err width"}, 64'(pwdErr), 64'(0));
    @(negedge clk);
  endtask

  task automatic loadPwd(input logic [63:0] val);
    pwdData = val;
    pwdLoad = 1'b1;
    @(negedge clk);
    pwdLoad = 1'b0;
  endtask

  initial begin
    #(PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #Q;
    check("R1 reset grant",  64'(grant), 0);
    check("R1 reset reject", 64'(reject), 0);
    check("R1 reset skip",   64'(skipMask), 0);
    check("R7 reset unlocked", 64'(pwdUnlocked), 0);
    check("R8 reset seclock",  64'(secLocked), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 plain requests
    drive("R1 prog free", 2'd0, 5, 0);
    drive("R1 erase free", 2'd1, 9, 0);

    // R3 pin, bottom then top boot
    wpPinN = 0; bootTop = 0;
    drive("R3 pin bottom s0", 2'd0, 0, 0);
    drive("R3 pin bottom s15", 2'd1, 15, 0);
    bootTop = 1;
    drive("R3 pin top s15", 2'd1, 15, 0);
    drive("R3 pin top s0", 2'd0, 0, 0);
    bootTop = 0;

    // R4 persistent bits
    ppbBits = 16'h0081;
    drive("R4 persist s7", 2'd0, 7, 0);
    drive("R4 persist erase s7", 2'd1, 7, 0);
    drive("R10 pin over persist s0", 2'd0, 0, 0);

    // R2 low supply wins
    lowSupply = 1;
    drive("R2 lowsup pin sector", 2'd0, 0, 0);
    drive("R2 lowsup chip erase", 2'd2, 0, 0);
    lowSupply = 0;

    // R9 chip erase skip mask
    drive("R9 chip erase skip", 2'd2, 3, 0);
    wpPinN = 1;
    drive("R9 chip erase no pin", 2'd2, 0, 0);
    wpPinN = 0;

    // R5 password mode locked
    pwdMode = 1;
    drive("R5 locked s7", 2'd0, 7, 0);
    drive("R10 pin over pwd s0", 2'd0, 0, 0);
    drive("R9 chip erase locked", 2'd2, 0, 0);

    // R7 load ignored while locked, R6 mismatch, R5 match with reset value
    loadPwd(64'h0000_1234_5678_9ABC);
    tryPwd("R6 wrong pwd", 64'h0000_0000_0000_0001, 1'b0);
    drive("R6 still locked s7", 2'd0, 7, 0);
    tryPwd("R7 reset pwd still valid", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    drive("R5 unlocked s7", 2'd0, 7, 0);
    drive("R9 chip erase unlocked", 2'd2, 0, 0);

    // R7 load while unlocked, relock, old rejected, new accepted
    loadPwd(64'hA5A5_5A5A_C3C3_3C3C);
    pwdLock = 1;
    @(negedge clk);
    pwdLock = 0;
    mUnlocked = 0;
    #Q;
    check("R7 relock", 64'(pwdUnlocked), 0);
    @(negedge clk);
    drive("R5 relocked s7", 2'd1, 7, 0);
    tryPwd("R7 old pwd rejected", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    tryPwd("R7 new pwd accepted", 64'hA5A5_5A5A_C3C3_3C3C, 1'b1);
    pwdMode = 0;

    // R8 secured region
    drive("R8 secured ignores pin", 2'd0, 0, 1);
    ppbBits = 16'hFFFF;
    drive("R8 secured ignores ppb", 2'd1, 4, 1);
    secLockSet = 1;
    @(negedge clk);
    secLockSet = 0;
    mSecLocked = 1;
    #Q;
    check("R8 seclock set", 64'(secLocked), 1);
    @(negedge clk);
    drive("R8 secured locked prog", 2'd0, 0, 1);
    drive("R8 secured locked erase", 2'd1, 2, 1);
    lowSupply = 1;
    drive("R10 lowsup over seclock", 2'd0, 0, 1);
    lowSupply = 0;
    repeat (3) @(negedge clk);
    #Q;
    check("R8 seclock sticky", 64'(secLocked), 1);

    @(negedge clk);
    #Q;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule